// File: doc/BRIEF.md
# Master-Guarded Interrupt Source Configuration Bank

This block holds the configuration of a set of interrupt sources in a multi-processor system. Each source has three fields: a 4-bit priority, a 4-bit mask of the processors the source is routed to, and a software-trigger level. The fields sit behind a simple register bus. That bus carries the 2-bit ID of the requesting processor (master) with every access and answers each request one cycle later. The block drives every source's priority, routing mask and software-trigger level straight out to the interrupt controller logic that uses them.

Writes are guarded. A protection register holds an enable bit and a 2-bit owner ID. While protection is off, any master may change anything. While it is on, only the owner may change routing masks, software triggers or the protection register itself. A priority may be changed by the owner or by any master that the source's current routing mask names. A write that breaks these rules changes nothing and returns an error on the response. Reads are never refused.

Top module: `irq_cfg_guard`

## Requirements
- R1: After reset every source has priority 0, an all-zero routing mask and its software trigger low. Protection is disabled and the owner ID is 0.
- R2: While protection is disabled, a write from any master to any field of any source, or to the protection register, takes effect and returns no error.
- R3: While protection is enabled, a write that enables the routing-mask group (byte-enable bit 1, data bits [7:4]) or the software-trigger group (byte-enable bit 2, data bit 8) is permitted only when the master ID equals the owner ID.
- R4: While protection is enabled, a write that enables the priority group (byte-enable bit 0, data bits [3:0]) is permitted when the master is the owner, or when bit m of that source's current routing mask is set for master m.
- R5: A write that is not permitted leaves every source and the protection register unchanged and raises the error flag on its response.
- R6: A write is all or nothing. If any field group it enables is not permitted, none of its groups are updated. A write with no byte-enable bit set changes nothing and returns no error.
- R7: Reads are never refused. A read of source i (address i) returns {7'b0, trigger, mask[3:0], priority[3:0]}. A read of the protection register (address N_SRC) returns owner ID in bits [5:4] and the enable bit in bit 0, with all other bits 0.
- R8: The protection register is written with byte-enable bit 0, taking the enable bit from data bit 0 and the owner ID from data bits [5:4]. While protection is enabled, only the current owner may write it.
- R9: Every request produces exactly one response-valid pulse in the following cycle. The error flag is only ever high together with response-valid. A write that is accepted shows its new values on the outputs in that same cycle.
- R10: An address above N_SRC reads as zero without error. A write to such an address returns an error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Source index, or N_SRC for the protection register |
| req_master_i | input | 2 | ID of the requesting master |
| req_be_i | input | 3 | Field-group enables: bit0 priority, bit1 mask, bit2 trigger |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Response pulse, one cycle after the request |
| rsp_err_o | output | 1 | Write refused; valid with rsp_valid_o |
| rsp_rdata_o | output | 16 | Read data (zero for writes) |
| src_prio_o | output | 4*N_SRC | Priority of each source, source i at bits [4i+3:4i] |
| src_route_o | output | 4*N_SRC | Routing mask of each source, source i at bits [4i+3:4i] |
| src_swt_o | output | N_SRC | Software-trigger level of each source |

## Verification
The hardest case to reach from the ports is a priority write by a master that is not the owner but is named in the source's routing mask while protection is on. A second hard case is the same master bundling a refused mask or trigger group into that write, which must cause an all-or-nothing rejection. Reaching either needs a specific history: the owner first loads a mask that names another master, and only then is protection enabled. Directed sequences build that history and probe both the accepted and the refused forms. Random traffic then keeps the protection register and the masks moving, so designated, undesignated and owner masters all meet enabled and disabled protection.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  localparam int unsigned MID_W  = 2;
  localparam int unsigned NMST   = 4;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BE_W   = 3;

  localparam int unsigned BE_PRIO = 0;
  localparam int unsigned BE_MASK = 1;
  localparam int unsigned BE_SWT  = 2;

  typedef logic [MID_W-1:0] mid_t;

  typedef struct packed {
    logic              swt;
    logic [NMST-1:0]   mask;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  function automatic logic [DATA_W-1:0] pack_src(input src_cfg_t c);
    logic [DATA_W-1:0] d;
    d = '0;
    d[PRIO_W-1:0] = c.prio;
    d[PRIO_W +: NMST] = c.mask;
    d[PRIO_W+NMST] = c.swt;
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] pack_prot(input logic en, input mid_t own);
    logic [DATA_W-1:0] d;
    d = '0;
    d[0] = en;
    d[5:4] = own;
    return d;
  endfunction
endpackage

// File: rtl/irq_cfg_access.sv
module irq_cfg_access
  import irq_cfg_pkg::*;
(
  input  logic            prot_en_i,
  input  mid_t            owner_i,
  input  mid_t            master_i,
  input  logic [BE_W-1:0] be_i,
  input  logic            in_range_i,
  input  logic            is_prot_i,
  input  logic [NMST-1:0] cur_mask_i,
  output logic            allow_o
);
  logic owner_hit;
  logic designated;
  logic restricted;

  always_comb begin
    owner_hit  = (master_i == owner_i);
    designated = cur_mask_i[master_i];
    restricted = be_i[BE_MASK] | be_i[BE_SWT];
    if (!in_range_i) begin
      allow_o = 1'b0;
    end else if (!prot_en_i) begin
      allow_o = 1'b1;
    end else if (is_prot_i) begin
      allow_o = !be_i[BE_PRIO] || owner_hit;
    end else begin
      allow_o = (!restricted || owner_hit) &&
                (!be_i[BE_PRIO] || owner_hit || designated);
    end
  end

  // R2: with protection off, every in-range target is open
  always_comb begin
    if (in_range_i && !prot_en_i) begin
      assert_open_when_off_R2: assert (allow_o);
    end
  end
endmodule

// File: rtl/irq_cfg_prot.sv
module irq_cfg_prot
  import irq_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output mid_t              owner_o
);
  logic en_q, en_d;
  mid_t own_q, own_d;

  always_comb begin
    en_d  = en_q;
    own_d = own_q;
    if (wr_i) begin
      en_d  = wdata_i[0];
      own_d = wdata_i[5:4];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      own_q <= '0;
    end else if (wr_i) begin
      en_q  <= en_d;
      own_q <= own_d;
    end
  end

  assign en_o    = en_q;
  assign owner_o = own_q;
endmodule

// File: rtl/irq_cfg_entry.sv
module irq_cfg_entry
  import irq_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output src_cfg_t          cfg_o
);
  src_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (be_i[BE_PRIO]) cfg_d.prio = wdata_i[PRIO_W-1:0];
    if (be_i[BE_MASK]) cfg_d.mask = wdata_i[PRIO_W +: NMST];
    if (be_i[BE_SWT])  cfg_d.swt  = wdata_i[PRIO_W+NMST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (upd_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/irq_cfg_guard.sv
module irq_cfg_guard
  import irq_cfg_pkg::*;
#(
  parameter  int unsigned N_SRC  = 8,
  localparam int unsigned ADDR_W = $clog2(N_SRC + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [1:0]             req_master_i,
  input  logic [2:0]             req_be_i,
  input  logic [15:0]            req_wdata_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_err_o,
  output logic [15:0]            rsp_rdata_o,
  output logic [4*N_SRC-1:0]     src_prio_o,
  output logic [4*N_SRC-1:0]     src_route_o,
  output logic [N_SRC-1:0]       src_swt_o
);
  localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(N_SRC);

  // reset: asserted at once, released on the clock
  logic rst_s1_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n    <= rst_s1_q;
    end
  end

  // decode
  logic is_entry, is_prot, in_range, allow, wr_ok, wr_bad;
  logic prot_en;
  mid_t owner;
  src_cfg_t cfg [N_SRC];
  src_cfg_t sel_cfg;

  always_comb begin
    is_entry = (req_addr_i < PROT_ADDR);
    is_prot  = (req_addr_i == PROT_ADDR);
    in_range = is_entry || is_prot;
    sel_cfg  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (is_entry && (req_addr_i == ADDR_W'(i))) sel_cfg = cfg[i];
    end
  end

  irq_cfg_access u_access (
    .prot_en_i  (prot_en),
    .owner_i    (owner),
    .master_i   (req_master_i),
    .be_i       (req_be_i),
    .in_range_i (in_range),
    .is_prot_i  (is_prot),
    .cur_mask_i (sel_cfg.mask),
    .allow_o    (allow)
  );

  assign wr_ok  = req_valid_i && req_write_i && allow;
  assign wr_bad = req_valid_i && req_write_i && !allow;

  irq_cfg_prot u_prot (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_i    (wr_ok && is_prot && req_be_i[BE_PRIO]),
    .wdata_i (req_wdata_i),
    .en_o    (prot_en),
    .owner_o (owner)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_cfg_entry u_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .upd_i   (wr_ok && is_entry && (req_addr_i == ADDR_W'(g))),
      .be_i    (req_be_i),
      .wdata_i (req_wdata_i),
      .cfg_o   (cfg[g])
    );
    assign src_prio_o[4*g +: 4]  = cfg[g].prio;
    assign src_route_o[4*g +: 4] = cfg[g].mask;
    assign src_swt_o[g]          = cfg[g].swt;
  end

  // response
  logic              vld_q, err_q, err_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    err_d = wr_bad;
    rd_d  = '0;
    if (!req_write_i) begin
      if (is_entry)     rd_d = pack_src(sel_cfg);
      else if (is_prot) rd_d = pack_prot(prot_en, owner);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      vld_q <= req_valid_i;
      err_q <= req_valid_i && err_d;
      if (req_valid_i) rd_q <= rd_d;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rd_q;

  // checks
  assert_rsp_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);
  assert_rsp_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);
  assert_err_with_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_err_o |-> rsp_valid_o);
  assert_reject_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_err_o |-> ($stable(src_prio_o) && $stable(src_route_o) && $stable(src_swt_o)));
  assert_read_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> !rsp_err_o);
  assert_open_no_err_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && req_write_i && !prot_en && in_range) |=> !rsp_err_o);
  assert_route_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && req_write_i && prot_en && (req_master_i != owner))
    |=> ($stable(src_route_o) && $stable(src_swt_o)));
  assert_far_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && req_write_i && !in_range) |=> rsp_err_o);
endmodule

// File: tb/test_irq_cfg_guard.sv
module test_irq_cfg_guard;
  localparam int N = 8;
  localparam int AW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] mst = '0;
  logic [2:0] be = '0;
  logic [15:0] wdata = '0;
  logic rsp_vld, rsp_err;
  logic [15:0] rsp_rd;
  logic [4*N-1:0] prio_o, route_o;
  logic [N-1:0] swt_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_prio [N];
  logic [3:0] m_mask [N];
  logic       m_swt  [N];
  logic       m_en;
  logic [1:0] m_own;

  always #5 clk = ~clk;

  irq_cfg_guard #(.N_SRC(N)) i_irq_cfg_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_master_i(mst), .req_be_i(be), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_vld), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rd),
    .src_prio_o(prio_o), .src_route_o(route_o), .src_swt_o(swt_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic w, input int a, input logic [1:0] m,
                                   input logic [2:0] b);
    logic own_hit;
    if (!w) return 1'b0;
    if (a > N) return 1'b1;
    if (!m_en) return 1'b0;
    own_hit = (m == m_own);
    if (a == N) return b[0] && !own_hit;
    if ((b[1] || b[2]) && !own_hit) return 1'b1;
    if (b[0] && !own_hit && !m_mask[a][m]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    if (a < N) return {7'b0, m_swt[a], m_mask[a], m_prio[a]};
    if (a == N) return {10'b0, m_own, 3'b0, m_en};
    return 16'h0;
  endfunction

  task automatic check_outputs(input string req);
    logic [4*N-1:0] ep, er;
    logic [N-1:0] es;
    for (int i = 0; i < N; i++) begin
      ep[4*i +: 4] = m_prio[i];
      er[4*i +: 4] = m_mask[i];
      es[i] = m_swt[i];
    end
    check({req, " prio"}, 64'(prio_o), 64'(ep));
    check({req, " route"}, 64'(route_o), 64'(er));
    check({req, " swt"}, 64'(swt_o), 64'(es));
  endtask

  // one access: drive at negedge, check one clock later at negedge
  task automatic access(input string req, input logic w, input int a, input logic [1:0] m,
                        input logic [2:0] b, input logic [15:0] d);
    logic e_err;
    logic [15:0] e_rd;
    e_err = exp_err(w, a, m, b);
    e_rd  = w ? 16'h0 : exp_rd(a);
    vld = 1'b1; wr = w; addr = AW'(a); mst = m; be = b; wdata = d;
    @(negedge clk);
    vld = 1'b0;
    if (w && !e_err) begin
      if (a < N) begin
        if (b[0]) m_prio[a] = d[3:0];
        if (b[1]) m_mask[a] = d[7:4];
        if (b[2]) m_swt[a]  = d[8];
      end else if (a == N && b[0]) begin
        m_en = d[0];
        m_own = d[5:4];
      end
    end
    check({req, " rsp_valid R9"}, 64'(rsp_vld), 64'd1);
    check({req, " rsp_err"}, 64'(rsp_err), 64'(e_err));
    if (!w) check({req, " rdata R7"}, 64'(rsp_rd), 64'(e_rd));
    check_outputs(req);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_prio[i] = '0; m_mask[i] = '0; m_swt[i] = 1'b0;
    end
    m_en = 1'b0; m_own = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_outputs("R1 reset");
    access("R1 prot reset read", 1'b0, N, 2'd2, 3'b000, 16'h0);
    @(negedge clk);
    check("R9 idle no valid", 64'(rsp_vld), 64'd0);

    // R2 open writes by non-zero masters
    access("R2 m2 full write", 1'b1, 3, 2'd2, 3'b111, 16'h01A5);
    access("R2 m3 full write", 1'b1, 5, 2'd3, 3'b111, 16'h0047);
    access("R2 m1 mask of src2", 1'b1, 2, 2'd1, 3'b010, 16'h0040);
    // R8 enable protection, owner 1, by master 3 while off
    access("R8 m3 enables prot", 1'b1, N, 2'd3, 3'b001, 16'h0011);
    access("R8 prot read", 1'b0, N, 2'd0, 3'b000, 16'h0);
    // R3 non-owner mask / trigger
    access("R3 m3 mask refused", 1'b1, 2, 2'd3, 3'b010, 16'h00F0);
    access("R3 m0 swt refused", 1'b1, 2, 2'd0, 3'b100, 16'h0100);
    access("R3 owner mask ok", 1'b1, 4, 2'd1, 3'b110, 16'h0130);
    // R4 designated master (src2 mask bit 2) may set priority
    access("R4 m2 designated prio", 1'b1, 2, 2'd2, 3'b001, 16'h0009);
    access("R4 m3 undesignated prio", 1'b1, 2, 2'd3, 3'b001, 16'h0003);
    access("R4 owner prio", 1'b1, 2, 2'd1, 3'b001, 16'h000C);
    // R6 all or nothing: designated prio + refused swt
    access("R6 partial refused", 1'b1, 2, 2'd2, 3'b101, 16'h0105);
    access("R6 no enables", 1'b1, 2, 2'd3, 3'b000, 16'h01FF);
    access("R7 read src2", 1'b0, 2, 2'd3, 3'b000, 16'h0);
    // R8 non-owner prot write
    access("R8 m0 prot refused", 1'b1, N, 2'd0, 3'b001, 16'h0000);
    // R10 out of range
    access("R10 far write", 1'b1, N + 3, 2'd1, 3'b111, 16'h01FF);
    access("R10 far read", 1'b0, N + 3, 2'd1, 3'b000, 16'h0);
    // R5 refused write leaves state, back-to-back with read
    access("R5 m0 refused", 1'b1, 4, 2'd0, 3'b111, 16'h0000);
    access("R5 read back", 1'b0, 4, 2'd0, 3'b000, 16'h0);

    // random traffic
    for (int k = 0; k < 1500; k++) begin
      int a;
      logic w;
      logic [15:0] d;
      a = ($urandom % 10 == 0) ? int'($urandom % (1 << AW)) : int'($urandom % (N + 1));
      w = ($urandom % 3) != 0;
      d = 16'($urandom);
      if (a == N && ($urandom % 2) == 0) d[0] = 1'b1;
      access("R3 R4 R5 R6 R8 random", w, a, 2'($urandom), 3'($urandom), d);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        check("R9 gap no valid", 64'(rsp_vld), 64'd0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule